// File: doc/BRIEF.md
# Posted-Read Debug Access Sequencer with Stall Recovery

This block sits between a debug controller and a scan-chain shifter of a debug port. The controller hands it one register request at a time (a debug-port access, an access-port access, or an end-of-batch status check). The sequencer turns each request into the scans the port needs. It writes the bank-select register only when the cached value would change. It follows every read with a read of the read buffer, because read data only comes back one scan late. When a scan is answered with a stall, it clears the sticky overrun flag, restores the select register and repeats the stalled scan. If the stall outlasts a cycle budget, it aborts the transfer.

The control is one state machine. `S_IDLE` accepts a request and goes to `S_SEL_WR` when a select write is needed, otherwise to `S_ACCESS`. `S_SEL_WR` goes to `S_ACCESS` on OK. `S_ACCESS` goes to `S_RDBUF` for a read and to `S_RESP` for a write. `S_RDBUF` goes to `S_RESP`, or to `S_STAT_CLR` when a status check finds the sticky error bit set. `S_STAT_CLR` goes to `S_RESP`. A stall in `S_SEL_WR` or `S_ACCESS` leads to `S_CLR_ORUN`. From there the machine returns to `S_SEL_WR`, or goes to `S_RESEL` (then `S_ACCESS`) or straight to `S_ACCESS` when the cache is invalid. A stall in `S_RDBUF`, `S_CLR_ORUN`, `S_RESEL` or `S_STAT_CLR` repeats that same state. A stall after the budget has run out goes to `S_ABORT_WR`, then `S_ABORT_CLR`, then `S_RESP`. A bad acknowledge in any non-abort scan state goes directly to `S_RESP`. `S_RESP` pulses the response and returns to `S_IDLE`.

Scan port encodings:
- Instruction: 0 = DP access, 1 = AP access, 2 = abort.
- Address field: register address bits [3:2].
- Status register: DP address 0x04, field value 01.
- Select register: 0x08, field value 10.
- Read buffer: 0x0C, field value 11.

Top module: `dbg_posted_seq`

## Requirements
- R1: For a read, the access scan (rnw=1) is followed by a DP scan with address field 11 and rnw=1. `rsp_rdata` equals the data returned by that second scan.
- R2: An AP access uses select value `{apnum, 16'h0, addr[7:4], 4'h0}`. A select write (DP, field 10, rnw=0, that value) comes first only when the cache is invalid or holds a different value; otherwise the access scan is first.
- R3: A DP access to any address other than 0x08 or 0x0C uses `{cache[31:4], addr[7:4]}`, or `{28'h0, addr[7:4]}` when the cache is invalid, with the same skip rule as R2. Accesses to 0x08 and 0x0C never cause a select write, and a DP write to 0x08 loads its data into the cache.
- R4: After reset the cache is invalid, so the first access writes the select register.
- R5: Acknowledge 3'b010 means OK and 3'b001 means stall. Any other code ends the request with `rsp_err`=2 and no further scans.
- R6: A stall on a select write or on an access scan causes a status write (field 01, data 0x00000002). For an access stall, this is followed by a select write of the cached value when the cache is valid. The stalled scan is then reissued.
- R7: A stall on the read-buffer scan repeats that scan with no clearing write, and the data of the first OK read-buffer scan is returned.
- R8: If a stall arrives once `TIMEOUT_CYC` cycles have passed since the request's first stall, the sequencer issues an abort scan with data 1, then a status write of 0x00000002. It then responds with `rsp_err`=1 and invalidates the cache.
- R9: A status check (`req_op`=2) is a DP read of 0x04 through R1. If bit 5 of the result is set, it writes 0x00000022 to the status register and responds with `rsp_err`=3. `rsp_rdata` holds the status value in both cases, and `rsp_err`=0 when bit 5 is clear.
- R10: `req_ready` is high only while idle, with `scan_valid` low. Each accepted request gets exactly one single-cycle `rsp_valid` pulse.
- R11: Out of reset, `req_ready`=1 while `scan_valid`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Controller request present |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_op | input | 2 | 0 DP access, 1 AP access, 2 status check |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 8 | Register address |
| req_apnum | input | 8 | Access-port number |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read or status data |
| rsp_err | output | 2 | 0 ok, 1 timeout, 2 bad acknowledge, 3 sticky error |
| scan_valid | output | 1 | Scan requested this cycle |
| scan_instr | output | 2 | Scan instruction |
| scan_addr | output | 2 | Register address bits [3:2] |
| scan_rnw | output | 1 | 1 read, 0 write |
| scan_wdata | output | 32 | Data shifted in |
| scan_done | input | 1 | Shifter finished the presented scan |
| scan_ack | input | 3 | Acknowledge captured by the scan |
| scan_rdata | input | 32 | Data captured by the scan |

## Verification
The assertions check, on every cycle, properties that hold in any state:
- `req_ready` excludes scan and response activity.
- Responses last exactly one cycle.
- An abort scan always writes 1.
- An AP scan only occurs with a valid select cache.
- A bad acknowledge leads to an invalid-acknowledge response on the next cycle.
- The timeout counter stays saturated until it is cleared.

The scan sequences themselves can only be shown by the bench's scenarios, which log every scan and compare the log with an arithmetic model of the select cache. These cover the select-skip sweep over port numbers and banks, the stall replay, read-buffer polling, the timeout abort and the sticky-error check.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int AP_W   = 8;

    localparam logic [1:0] SI_DPACC = 2'd0;
    localparam logic [1:0] SI_APACC = 2'd1;
    localparam logic [1:0] SI_ABORT = 2'd2;

    localparam logic [2:0] ACK_OK   = 3'b010;
    localparam logic [2:0] ACK_WAIT = 3'b001;

    localparam logic [1:0] OP_DP    = 2'd0;
    localparam logic [1:0] OP_AP    = 2'd1;
    localparam logic [1:0] OP_CHECK = 2'd2;

    localparam logic [1:0] ERR_NONE    = 2'd0;
    localparam logic [1:0] ERR_TIMEOUT = 2'd1;
    localparam logic [1:0] ERR_BADACK  = 2'd2;
    localparam logic [1:0] ERR_STICKY  = 2'd3;

    localparam logic [ADDR_W-1:0] REG_STATUS = 8'h04;
    localparam logic [ADDR_W-1:0] REG_SELECT = 8'h08;
    localparam logic [ADDR_W-1:0] REG_RDBUF  = 8'h0C;

    localparam int STICKY_ERR_BIT = 5;
    localparam logic [DATA_W-1:0] CLR_ORUN_VAL = 32'h0000_0002;
    localparam logic [DATA_W-1:0] CLR_ALL_VAL  = 32'h0000_0022;
endpackage

// File: rtl/dbgseq_selcalc.sv
module dbgseq_selcalc
    import dbgseq_pkg::*;
(
    input  logic              is_ap,
    input  logic [ADDR_W-1:0] addr,
    input  logic [AP_W-1:0]   apnum,
    input  logic [DATA_W-1:0] cache,
    input  logic              cache_ok,
    output logic [DATA_W-1:0] want,
    output logic              need
);
    localparam int BANK_W = 4;
    localparam int PAD_W  = DATA_W - AP_W - 2 * BANK_W;

    logic [BANK_W-1:0] bank;
    logic              unbanked;

    assign bank     = addr[2*BANK_W-1:BANK_W];
    assign unbanked = (addr == REG_SELECT) || (addr == REG_RDBUF);

    always_comb begin
        if (is_ap) begin
            want = {apnum, {PAD_W{1'b0}}, bank, {BANK_W{1'b0}}};
            need = !cache_ok || (want != cache);
        end else if (unbanked) begin
            want = cache;
            need = 1'b0;
        end else begin
            want = cache_ok ? {cache[DATA_W-1:BANK_W], bank}
                            : {{(DATA_W-BANK_W){1'b0}}, bank};
            need = !cache_ok || (want != cache);
        end
    end
endmodule

// File: rtl/dbgseq_timer.sv
module dbgseq_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (run && cnt != LIM)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LIM);

    // R8
    tmo_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clear) |=> expired);

    // R8
    tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM);
endmodule

// File: rtl/dbg_posted_seq.sv
module dbg_posted_seq
    import dbgseq_pkg::*;
#(
    parameter int TIMEOUT_CYC = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_op,
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic [7:0]  req_apnum,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic [1:0]  rsp_err,
    output logic        scan_valid,
    output logic [1:0]  scan_instr,
    output logic [1:0]  scan_addr,
    output logic        scan_rnw,
    output logic [31:0] scan_wdata,
    input  logic        scan_done,
    input  logic [2:0]  scan_ack,
    input  logic [31:0] scan_rdata
);
    typedef enum logic [3:0] {
        S_IDLE, S_SEL_WR, S_ACCESS, S_RDBUF, S_CLR_ORUN,
        S_RESEL, S_ABORT_WR, S_ABORT_CLR, S_STAT_CLR, S_RESP
    } state_e;

    state_e st, nxt;

    logic [1:0]        op_q;
    logic              wr_q;
    logic              ap_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] want_q;
    logic [DATA_W-1:0] sel_cache;
    logic              sel_ok;
    logic [DATA_W-1:0] rdata_q;
    logic [1:0]        err_q;
    logic              wait_seen;
    logic              retry_access;

    logic              accept;
    logic              req_is_ap;
    logic [ADDR_W-1:0] req_eff_addr;
    logic [DATA_W-1:0] sel_want;
    logic              sel_need;
    logic              tmo_hit;
    logic              ack_ok, ack_wait, ack_bad;
    logic              in_abort;

    assign accept       = (st == S_IDLE) && req_valid;
    assign req_is_ap    = (req_op == OP_AP);
    assign req_eff_addr = (req_op == OP_CHECK) ? REG_STATUS : req_addr;
    assign ack_ok       = (scan_ack == ACK_OK);
    assign ack_wait     = (scan_ack == ACK_WAIT);
    assign ack_bad      = !ack_ok && !ack_wait;
    assign in_abort     = (st == S_ABORT_WR) || (st == S_ABORT_CLR);

    dbgseq_selcalc u_selcalc (
        .is_ap    (req_is_ap),
        .addr     (req_eff_addr),
        .apnum    (req_apnum),
        .cache    (sel_cache),
        .cache_ok (sel_ok),
        .want     (sel_want),
        .need     (sel_need)
    );

    dbgseq_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .run     (wait_seen),
        .expired (tmo_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:      if (req_valid) nxt = sel_need ? S_SEL_WR : S_ACCESS;
            S_ABORT_WR:  if (scan_done) nxt = S_ABORT_CLR;
            S_ABORT_CLR: if (scan_done) nxt = S_RESP;
            S_RESP:      nxt = S_IDLE;
            default: begin
                if (scan_done) begin
                    if (ack_bad) begin
                        nxt = S_RESP;
                    end else if (ack_wait) begin
                        if (tmo_hit)
                            nxt = S_ABORT_WR;
                        else if (st == S_SEL_WR || st == S_ACCESS)
                            nxt = S_CLR_ORUN;
                        else
                            nxt = st;
                    end else begin
                        case (st)
                            S_SEL_WR:   nxt = S_ACCESS;
                            S_ACCESS:   nxt = wr_q ? S_RESP : S_RDBUF;
                            S_RDBUF:    nxt = (op_q == OP_CHECK && scan_rdata[STICKY_ERR_BIT])
                                              ? S_STAT_CLR : S_RESP;
                            S_CLR_ORUN: nxt = !retry_access ? S_SEL_WR
                                              : (sel_ok ? S_RESEL : S_ACCESS);
                            S_RESEL:    nxt = S_ACCESS;
                            S_STAT_CLR: nxt = S_RESP;
                            default:    nxt = S_IDLE;
                        endcase
                    end
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = (st == S_IDLE);
        rsp_valid  = (st == S_RESP);
        scan_valid = 1'b1;
        scan_instr = SI_DPACC;
        scan_addr  = 2'b00;
        scan_rnw   = 1'b0;
        scan_wdata = '0;
        unique case (st)
            S_SEL_WR: begin
                scan_addr  = REG_SELECT[3:2];
                scan_wdata = want_q;
            end
            S_ACCESS: begin
                scan_instr = ap_q ? SI_APACC : SI_DPACC;
                scan_addr  = addr_q[3:2];
                scan_rnw   = !wr_q;
                scan_wdata = wr_q ? wdata_q : '0;
            end
            S_RDBUF: begin
                scan_addr = REG_RDBUF[3:2];
                scan_rnw  = 1'b1;
            end
            S_CLR_ORUN, S_ABORT_CLR: begin
                scan_addr  = REG_STATUS[3:2];
                scan_wdata = CLR_ORUN_VAL;
            end
            S_RESEL: begin
                scan_addr  = REG_SELECT[3:2];
                scan_wdata = sel_cache;
            end
            S_ABORT_WR: begin
                scan_instr = SI_ABORT;
                scan_wdata = 32'd1;
            end
            S_STAT_CLR: begin
                scan_addr  = REG_STATUS[3:2];
                scan_wdata = CLR_ALL_VAL;
            end
            default: scan_valid = 1'b0;
        endcase
    end

    // request context, select cache, result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q         <= OP_DP;
            wr_q         <= 1'b0;
            ap_q         <= 1'b0;
            addr_q       <= '0;
            wdata_q      <= '0;
            want_q       <= '0;
            sel_cache    <= '0;
            sel_ok       <= 1'b0;
            rdata_q      <= '0;
            err_q        <= ERR_NONE;
            wait_seen    <= 1'b0;
            retry_access <= 1'b0;
        end else if (accept) begin
            op_q      <= req_op;
            wr_q      <= (req_op == OP_CHECK) ? 1'b0 : req_write;
            ap_q      <= req_is_ap;
            addr_q    <= req_eff_addr;
            wdata_q   <= req_wdata;
            want_q    <= sel_want;
            rdata_q   <= '0;
            err_q     <= ERR_NONE;
            wait_seen <= 1'b0;
        end else if (scan_valid && scan_done) begin
            if (in_abort) begin
                if (st == S_ABORT_CLR) begin
                    err_q  <= ERR_TIMEOUT;
                    sel_ok <= 1'b0;
                end
            end else if (ack_bad) begin
                err_q <= ERR_BADACK;
            end else if (ack_wait) begin
                wait_seen <= 1'b1;
                if (st == S_SEL_WR) retry_access <= 1'b0;
                if (st == S_ACCESS) retry_access <= 1'b1;
            end else begin
                case (st)
                    S_SEL_WR: begin
                        sel_cache <= want_q;
                        sel_ok    <= 1'b1;
                    end
                    S_ACCESS: begin
                        if (!ap_q && wr_q && addr_q == REG_SELECT) begin
                            sel_cache <= wdata_q;
                            sel_ok    <= 1'b1;
                        end
                    end
                    S_RDBUF: begin
                        rdata_q <= scan_rdata;
                        if (op_q == OP_CHECK && scan_rdata[STICKY_ERR_BIT])
                            err_q <= ERR_STICKY;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rsp_rdata = rdata_q;
    assign rsp_err   = err_q;

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!scan_valid && !rsp_valid));

    // R10
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    abort_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && scan_instr == SI_ABORT) |-> (scan_wdata == 32'd1 && !scan_rnw));

    // R4
    ap_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && scan_instr == SI_APACC) |-> sel_ok);

    // R5
    badack_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && scan_done && !in_abort && ack_bad) |=> (rsp_valid && rsp_err == ERR_BADACK));
endmodule

// File: tb/sim_dbg_posted_seq.sv
module sim_dbg_posted_seq;
    localparam int TMO = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = 8'h0;
    logic [7:0]  req_apnum = 8'h0;
    logic [31:0] req_wdata = 32'h0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [1:0]  rsp_err;
    logic        scan_valid;
    logic [1:0]  scan_instr;
    logic [1:0]  scan_addr;
    logic        scan_rnw;
    logic [31:0] scan_wdata;
    logic        scan_done = 1'b0;
    logic [2:0]  scan_ack = 3'b010;
    logic [31:0] scan_rdata = 32'h0;

    always #2 clk = ~clk;

    dbg_posted_seq #(.TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_write(req_write), .req_addr(req_addr), .req_apnum(req_apnum),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .scan_valid(scan_valid), .scan_instr(scan_instr),
        .scan_addr(scan_addr), .scan_rnw(scan_rnw), .scan_wdata(scan_wdata),
        .scan_done(scan_done), .scan_ack(scan_ack), .scan_rdata(scan_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;

    // scan log and acknowledge script of the shifter model
    logic [1:0]  lg_instr [64];
    logic [1:0]  lg_addr  [64];
    logic        lg_rnw   [64];
    logic [31:0] lg_wd    [64];
    int          lg_n = 0;
    logic [2:0]  scr [8];
    int          scr_n = 0;
    int          scr_p = 0;
    bit          wait_all = 1'b0;
    logic [31:0] rd_val = 32'h0;

    always @(negedge clk) begin
        if (rst_n && scan_valid) begin
            if (lg_n < 64) begin
                lg_instr[lg_n] = scan_instr;
                lg_addr[lg_n]  = scan_addr;
                lg_rnw[lg_n]   = scan_rnw;
                lg_wd[lg_n]    = scan_wdata;
            end
            lg_n++;
            if (wait_all)
                scan_ack = 3'b001;
            else if (scr_p < scr_n) begin
                scan_ack = scr[scr_p];
                scr_p++;
            end else
                scan_ack = 3'b010;
            scan_rdata = rd_val;
            scan_done  = 1'b1;
        end else begin
            scan_done = 1'b0;
        end
    end

    task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic scan_is(string rq, int i, logic [1:0] ins, logic [1:0] a, logic rnw, logic [31:0] wd);
        if (i >= lg_n || i >= 64)
            chk(rq, "scan present", 64'(i), 64'(lg_n));
        else
            chk(rq, $sformatf("scan %0d", i), {27'd0, lg_instr[i], lg_addr[i], lg_rnw[i], lg_wd[i]},
                {27'd0, ins, a, rnw, wd});
    endtask

    logic [31:0] got_rd;
    logic [1:0]  got_err;

    task automatic do_req(logic [1:0] op, logic wr, logic [7:0] ad, logic [7:0] ap, logic [31:0] wd);
        int guard;
        int pulses;
        lg_n  = 0;
        scr_p = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_write = wr;
        req_addr = ad; req_apnum = ap; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!rsp_valid && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        got_rd  = rsp_rdata;
        got_err = rsp_err;
        pulses  = rsp_valid ? 1 : 0;
        @(negedge clk);
        if (rsp_valid) pulses++;
        // R10: exactly one single-cycle response
        chk("R10", "response pulses", 64'(pulses), 64'd1);
    endtask

    function automatic logic [31:0] ap_sel(logic [7:0] ap, logic [7:0] ad);
        return {ap, 16'h0, ad[7:4], 4'h0};
    endfunction

    logic [31:0] mc;
    bit          mv;

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "ready/scan/rsp", {61'd0, req_ready, scan_valid, rsp_valid}, 64'b100);

        // R4, R2, R1: first AP read writes select, then access, then read buffer
        rd_val = 32'h1234_5678;
        do_req(2'd1, 1'b0, 8'h14, 8'h03, 32'h0);
        chk("R4", "scan count", 64'(lg_n), 64'd3);
        scan_is("R2", 0, 2'd0, 2'b10, 1'b0, 32'h0300_0010);
        scan_is("R1", 1, 2'd1, 2'b01, 1'b1, 32'h0);
        scan_is("R1", 2, 2'd0, 2'b11, 1'b1, 32'h0);
        chk("R1", "read data", 64'(got_rd), 64'h1234_5678);
        mc = 32'h0300_0010; mv = 1'b1;

        // R2 sweep: port number x bank, each twice
        for (int ap = 0; ap < 4; ap++) begin
            for (int bk = 0; bk < 4; bk++) begin
                for (int rp = 0; rp < 2; rp++) begin
                    logic [7:0]  ad;
                    logic [31:0] w;
                    bit          nd;
                    ad = {4'(bk), 4'h4};
                    w  = ap_sel(8'(ap), ad);
                    nd = !mv || (w != mc);
                    do_req(2'd1, 1'b1, ad, 8'(ap), 32'hA500_0000 + 32'(ap * 16 + bk));
                    chk("R2", "sweep scan count", 64'(lg_n), nd ? 64'd2 : 64'd1);
                    if (nd) scan_is("R2", 0, 2'd0, 2'b10, 1'b0, w);
                    scan_is("R2", nd ? 1 : 0, 2'd1, 2'b01, 1'b0, 32'hA500_0000 + 32'(ap * 16 + bk));
                    mc = w; mv = 1'b1;
                end
            end
        end

        // R3: banked DP read merges bank into low nibble
        rd_val = 32'h0BAD_F00D;
        do_req(2'd0, 1'b0, 8'h24, 8'h00, 32'h0);
        chk("R3", "dp bank scans", 64'(lg_n), 64'd3);
        scan_is("R3", 0, 2'd0, 2'b10, 1'b0, {mc[31:4], 4'h2});
        scan_is("R3", 1, 2'd0, 2'b01, 1'b1, 32'h0);
        chk("R1", "dp read data", 64'(got_rd), 64'h0BAD_F00D);
        mc = {mc[31:4], 4'h2};

        // R3: direct select write loads cache
        do_req(2'd0, 1'b1, 8'h08, 8'h00, 32'h0500_0030);
        chk("R3", "select write scans", 64'(lg_n), 64'd1);
        scan_is("R3", 0, 2'd0, 2'b10, 1'b0, 32'h0500_0030);
        mc = 32'h0500_0030;
        do_req(2'd1, 1'b1, 8'h34, 8'h05, 32'h77);
        chk("R3", "cache loaded by write", 64'(lg_n), 64'd1);

        // R3: read-buffer address never switches bank
        do_req(2'd0, 1'b0, 8'h0C, 8'h00, 32'h0);
        chk("R3", "rdbuf scans", 64'(lg_n), 64'd2);
        scan_is("R3", 0, 2'd0, 2'b11, 1'b1, 32'h0);

        // R6: stall on access -> clear, reselect, replay
        scr[0] = 3'b001; scr_n = 1;
        do_req(2'd1, 1'b1, 8'h34, 8'h05, 32'hDEAD_0001);
        scr_n = 0;
        chk("R6", "replay scan count", 64'(lg_n), 64'd4);
        scan_is("R6", 1, 2'd0, 2'b01, 1'b0, 32'h2);
        scan_is("R6", 2, 2'd0, 2'b10, 1'b0, mc);
        scan_is("R6", 3, 2'd1, 2'b01, 1'b0, 32'hDEAD_0001);
        chk("R6", "err", 64'(got_err), 64'd0);

        // R7: stalled read-buffer polled
        scr[0] = 3'b010; scr[1] = 3'b001; scr[2] = 3'b001; scr_n = 3;
        rd_val = 32'hCAFE_0001;
        do_req(2'd1, 1'b0, 8'h38, 8'h05, 32'h0);
        scr_n = 0;
        chk("R7", "poll scan count", 64'(lg_n), 64'd4);
        scan_is("R7", 3, 2'd0, 2'b11, 1'b1, 32'h0);
        chk("R7", "read data", 64'(got_rd), 64'hCAFE_0001);

        // R5: bad acknowledge
        scr[0] = 3'b100; scr_n = 1;
        do_req(2'd1, 1'b1, 8'h34, 8'h05, 32'h1);
        scr_n = 0;
        chk("R5", "scan count", 64'(lg_n), 64'd1);
        chk("R5", "err", 64'(got_err), 64'd2);

        // R9: status check clean, then with sticky error
        rd_val = 32'h0000_0040;
        do_req(2'd2, 1'b0, 8'h00, 8'h00, 32'h0);
        chk("R9", "clean scans", 64'(lg_n), 64'd2);
        scan_is("R9", 0, 2'd0, 2'b01, 1'b1, 32'h0);
        chk("R9", "clean err", 64'(got_err), 64'd0);
        rd_val = 32'h0000_0020;
        do_req(2'd2, 1'b0, 8'h00, 8'h00, 32'h0);
        chk("R9", "sticky scans", 64'(lg_n), 64'd3);
        scan_is("R9", 2, 2'd0, 2'b01, 1'b0, 32'h22);
        chk("R9", "sticky err", 64'(got_err), 64'd3);
        chk("R9", "status data", 64'(got_rd), 64'h20);

        // R8: persistent stall -> abort, then select is rewritten
        wait_all = 1'b1;
        do_req(2'd1, 1'b1, 8'h34, 8'h05, 32'h9);
        wait_all = 1'b0;
        chk("R8", "err", 64'(got_err), 64'd1);
        if (lg_n >= 2 && lg_n <= 64) begin
            scan_is("R8", lg_n - 2, 2'd2, 2'b00, 1'b0, 32'h1);
            scan_is("R8", lg_n - 1, 2'd0, 2'b01, 1'b0, 32'h2);
        end else
            chk("R8", "abort scan count", 64'(lg_n), 64'd2);
        do_req(2'd1, 1'b1, 8'h34, 8'h05, 32'h9);
        chk("R8", "post-abort scans", 64'(lg_n), 64'd2);
        scan_is("R8", 0, 2'd0, 2'b10, 1'b0, 32'h0500_0030);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule